// File: doc/BRIEF.md
# USB Device Handshake Response Selector

This block picks the handshake that a USB device controller sends back after each decoded token. The token decoder presents a token kind, the addressed endpoint number and a valid pulse. From these, the block looks up the bank-ready and stall flags of that endpoint. It then applies three controls on top of the normal bank-status answer. The first is a global NAK override. The second is a no-reply mode for endpoint 0 that silences everything except SETUP. The third is a two-bit selector that fixes the answer to Link Power Management tokens.

The result is a one-cycle response strobe together with a response code. The block also owns the no-reply flag. Firmware sets or clears the flag through a single-bit write port, and any received SETUP clears it automatically.

Top module: `usb_hs_resp_sel`

## Requirements
- R1: `resp_valid` is high in the cycle after the clock edge that samples `tok_valid` high, and low after an edge that samples `tok_valid` low. Whenever `resp_valid` is low, `resp_code` is 0.
- R2: A SETUP token (kind 0) is answered ACK on any endpoint, whatever the global NAK, no-reply, stall or ready inputs are.
- R3: The clock edge that samples a SETUP token clears the no-reply flag. This clear wins over a write of 1 on the same edge.
- R4: A write (`nr_wr_en` high) with no SETUP on the same edge loads `nr_wr_data` into the no-reply flag, which shows on `nr_state` from the next cycle.
- R5: While the no-reply flag is set, IN (1), OUT (2) and PING (3) tokens to endpoint 0 get response code 0 (no reply).
- R6: The no-reply flag has no effect on tokens to endpoints other than 0.
- R7: With `gnak_en` high, IN, OUT and PING tokens that R5 does not silence are answered NAK, regardless of the stall and ready flags.
- R8: With `gnak_en` low, an IN, OUT or PING token to an endpoint whose stall bit is set is answered STALL.
- R9: With `gnak_en` low and the stall bit clear, an IN, OUT or PING token is answered ACK if the endpoint's ready bit is set, and NAK otherwise. Only the bits of the addressed endpoint matter.
- R10: An LPM token (kind 4) is answered according to `lpm_sel`: 1 gives ACK, 2 gives NYET, and 0 or 3 give no reply. Global NAK, no-reply, the endpoint number and the endpoint flags do not affect it.
- R11: During and right after reset, `resp_valid` is 0, `resp_code` is 0 and `nr_state` is 0.
- R12: Token kinds 5 to 7 produce a strobe with response code 0.
- R13: Response codes are: 0 no reply, 1 ACK, 2 NAK, 3 NYET, 4 STALL.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tok_valid | input | 1 | A decoded token is present this cycle |
| tok_kind | input | 3 | Token kind: 0 SETUP, 1 IN, 2 OUT, 3 PING, 4 LPM |
| tok_ep | input | EP_W | Addressed endpoint number |
| ep_ready | input | 2**EP_W | Per-endpoint bank ready flags |
| ep_stall | input | 2**EP_W | Per-endpoint stall flags |
| gnak_en | input | 1 | Global NAK override |
| lpm_sel | input | 2 | LPM answer selector |
| nr_wr_en | input | 1 | Write strobe for the no-reply flag |
| nr_wr_data | input | 1 | Value written to the no-reply flag |
| nr_state | output | 1 | Current no-reply flag |
| resp_valid | output | 1 | One-cycle response strobe |
| resp_code | output | 3 | Response code (R13) |

## Verification
The hardest situation to reach from the ports is a token to endpoint 0 that arrives while the no-reply flag is already set. The flag only holds a 1 if a write landed on an earlier edge and no SETUP has cleared it since. To get there, the bench writes the flag one cycle before every swept token. It then sweeps every token kind, endpoint, flag combination and selector value. Each addressed endpoint's flags are set opposite to all the other endpoints' flags, so any wrong-endpoint lookup shows up. A separate sequence drives a SETUP token on the same edge as a write of 1 to check that the hardware clear wins.

// File: rtl/usb_hs_pkg.sv
package usb_hs_pkg;

    localparam int KIND_W = 3;
    localparam int CODE_W = 3;

    localparam logic [KIND_W-1:0] TK_SETUP = 3'd0;
    localparam logic [KIND_W-1:0] TK_IN    = 3'd1;
    localparam logic [KIND_W-1:0] TK_OUT   = 3'd2;
    localparam logic [KIND_W-1:0] TK_PING  = 3'd3;
    localparam logic [KIND_W-1:0] TK_LPM   = 3'd4;

    localparam logic [1:0] LPM_NONE = 2'd0;
    localparam logic [1:0] LPM_ACK  = 2'd1;
    localparam logic [1:0] LPM_NYET = 2'd2;

    typedef enum logic [CODE_W-1:0] {
        RSP_NONE  = 3'd0,
        RSP_ACK   = 3'd1,
        RSP_NAK   = 3'd2,
        RSP_NYET  = 3'd3,
        RSP_STALL = 3'd4
    } resp_e;

    typedef struct packed {
        logic  valid;
        resp_e code;
    } resp_t;

endpackage

// File: rtl/usb_hs_ep_sel.sv
module usb_hs_ep_sel #(
    parameter int EP_W = 4,
    localparam int N_EP = 1 << EP_W
) (
    input  logic [EP_W-1:0] ep,
    input  logic [N_EP-1:0] ready,
    input  logic [N_EP-1:0] stall,
    output logic            sel_ready,
    output logic            sel_stall,
    output logic            is_ep0
);

    logic [N_EP-1:0] hit;

    for (genvar g = 0; g < N_EP; g++) begin : g_hit
        assign hit[g] = (ep == EP_W'(g));
    end

    assign sel_ready = |(hit & ready);
    assign sel_stall = |(hit & stall);
    assign is_ep0    = hit[0];

endmodule

// File: rtl/usb_hs_nr_reg.sv
module usb_hs_nr_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic setup_hit,
    input  logic wr_en,
    input  logic wr_data,
    output logic nr_q
);

    logic nr_d;

    always_comb begin
        nr_d = nr_q;
        if (wr_en) begin
            nr_d = wr_data;
        end
        if (setup_hit) begin
            nr_d = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nr_q <= 1'b0;
        end else begin
            nr_q <= nr_d;
        end
    end

    // R3
    setup_clears_nr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        setup_hit |=> !nr_q);

    // R4
    write_loads_nr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !setup_hit) |=> (nr_q == $past(wr_data)));

    // R4
    nr_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !setup_hit) |=> $stable(nr_q));

endmodule

// File: rtl/usb_hs_resp_rule.sv
module usb_hs_resp_rule
    import usb_hs_pkg::*;
(
    input  logic [KIND_W-1:0] kind,
    input  logic              is_ep0,
    input  logic              nr,
    input  logic              gnak,
    input  logic              rdy,
    input  logic              stl,
    input  logic [1:0]        lpm_sel,
    output resp_e             code
);

    always_comb begin
        code = RSP_NONE;
        unique case (kind)
            TK_SETUP: code = RSP_ACK;
            TK_LPM: begin
                if (lpm_sel == LPM_ACK) begin
                    code = RSP_ACK;
                end else if (lpm_sel == LPM_NYET) begin
                    code = RSP_NYET;
                end else begin
                    code = RSP_NONE;
                end
            end
            TK_IN, TK_OUT, TK_PING: begin
                if (is_ep0 && nr) begin
                    code = RSP_NONE;
                end else if (gnak) begin
                    code = RSP_NAK;
                end else if (stl) begin
                    code = RSP_STALL;
                end else if (rdy) begin
                    code = RSP_ACK;
                end else begin
                    code = RSP_NAK;
                end
            end
            default: code = RSP_NONE;
        endcase
    end

endmodule

// File: rtl/usb_hs_resp_sel.sv
module usb_hs_resp_sel
    import usb_hs_pkg::*;
#(
    parameter int EP_W = 4,
    localparam int N_EP = 1 << EP_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tok_valid,
    input  logic [KIND_W-1:0] tok_kind,
    input  logic [EP_W-1:0]   tok_ep,
    input  logic [N_EP-1:0]   ep_ready,
    input  logic [N_EP-1:0]   ep_stall,
    input  logic              gnak_en,
    input  logic [1:0]        lpm_sel,
    input  logic              nr_wr_en,
    input  logic              nr_wr_data,
    output logic              nr_state,
    output logic              resp_valid,
    output logic [CODE_W-1:0] resp_code
);

    logic  sel_ready;
    logic  sel_stall;
    logic  is_ep0;
    logic  setup_hit;
    resp_e rule_code;
    resp_t resp_d;
    resp_t resp_q;

    assign setup_hit = tok_valid && (tok_kind == TK_SETUP);

    usb_hs_ep_sel #(.EP_W(EP_W)) u_ep_sel (
        .ep        (tok_ep),
        .ready     (ep_ready),
        .stall     (ep_stall),
        .sel_ready (sel_ready),
        .sel_stall (sel_stall),
        .is_ep0    (is_ep0)
    );

    usb_hs_nr_reg u_nr_reg (
        .clk       (clk),
        .rst_n     (rst_n),
        .setup_hit (setup_hit),
        .wr_en     (nr_wr_en),
        .wr_data   (nr_wr_data),
        .nr_q      (nr_state)
    );

    usb_hs_resp_rule u_rule (
        .kind    (tok_kind),
        .is_ep0  (is_ep0),
        .nr      (nr_state),
        .gnak    (gnak_en),
        .rdy     (sel_ready),
        .stl     (sel_stall),
        .lpm_sel (lpm_sel),
        .code    (rule_code)
    );

    always_comb begin
        resp_d.valid = tok_valid;
        resp_d.code  = tok_valid ? rule_code : RSP_NONE;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_q <= '{valid: 1'b0, code: RSP_NONE};
        end else begin
            resp_q <= resp_d;
        end
    end

    assign resp_valid = resp_q.valid;
    assign resp_code  = resp_q.code;

    // R1
    strobe_follows_tok_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tok_valid |=> resp_valid);

    // R1
    strobe_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tok_valid |=> !resp_valid);

    // R1
    idle_code_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !resp_valid |-> (resp_code == '0));

    // R2
    setup_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        setup_hit |=> (resp_code == RSP_ACK));

    // R5
    ep0_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tok_valid && nr_state && tok_ep == '0
         && (tok_kind == TK_IN || tok_kind == TK_OUT || tok_kind == TK_PING))
        |=> (resp_code == RSP_NONE));

    // R7
    gnak_nak_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tok_valid && gnak_en && !(nr_state && tok_ep == '0)
         && (tok_kind == TK_IN || tok_kind == TK_OUT || tok_kind == TK_PING))
        |=> (resp_code == RSP_NAK));

    // R10
    lpm_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tok_valid && tok_kind == TK_LPM && (lpm_sel == 2'd0 || lpm_sel == 2'd3))
        |=> (resp_code == RSP_NONE));

endmodule

// File: tb/usb_hs_resp_sel_bench.sv
`timescale 1ns/1ps
module usb_hs_resp_sel_bench;

    localparam int EP_W = 4;
    localparam int N_EP = 1 << EP_W;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            tok_valid = 1'b0;
    logic [2:0]      tok_kind = '0;
    logic [EP_W-1:0] tok_ep = '0;
    logic [N_EP-1:0] ep_ready = '0;
    logic [N_EP-1:0] ep_stall = '0;
    logic            gnak_en = 1'b0;
    logic [1:0]      lpm_sel = '0;
    logic            nr_wr_en = 1'b0;
    logic            nr_wr_data = 1'b0;
    logic            nr_state;
    logic            resp_valid;
    logic [2:0]      resp_code;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    usb_hs_resp_sel #(.EP_W(EP_W)) u_usb_hs_resp_sel (
        .clk        (clk),
        .rst_n      (rst_n),
        .tok_valid  (tok_valid),
        .tok_kind   (tok_kind),
        .tok_ep     (tok_ep),
        .ep_ready   (ep_ready),
        .ep_stall   (ep_stall),
        .gnak_en    (gnak_en),
        .lpm_sel    (lpm_sel),
        .nr_wr_en   (nr_wr_en),
        .nr_wr_data (nr_wr_data),
        .nr_state   (nr_state),
        .resp_valid (resp_valid),
        .resp_code  (resp_code)
    );

    task automatic check(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // R13 code values: 0 none, 1 ACK, 2 NAK, 3 NYET, 4 STALL
    function automatic int expect_code(int kind, int ep, int rdy, int stl,
                                       int g, int nr, int lpm);
        if (kind == 0) return 1;
        if (kind == 4) return (lpm == 1) ? 1 : (lpm == 2) ? 3 : 0;
        if (kind >= 5) return 0;
        if (ep == 0 && nr == 1) return 0;
        if (g == 1) return 2;
        if (stl == 1) return 4;
        return (rdy == 1) ? 1 : 2;
    endfunction

    function automatic string req_of(int kind, int ep, int stl, int g, int nr);
        if (kind == 0) return "R2";
        if (kind == 4) return "R10";
        if (kind >= 5) return "R12";
        if (ep == 0 && nr == 1) return "R5";
        if (nr == 1 && ep != 0 && g == 0) return "R6";
        if (g == 1) return "R7";
        if (stl == 1) return "R8";
        return "R9";
    endfunction

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11 reset state
        check("R11", int'(resp_valid), 0);
        check("R11", int'(resp_code), 0);
        check("R11", int'(nr_state), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R11", int'(resp_valid), 0);
        check("R11", int'(nr_state), 0);

        // R4 write 1, then write 0
        nr_wr_en = 1'b1; nr_wr_data = 1'b1;
        @(negedge clk);
        nr_wr_en = 1'b0;
        check("R4", int'(nr_state), 1);
        @(negedge clk);
        check("R4", int'(nr_state), 1);
        nr_wr_en = 1'b1; nr_wr_data = 1'b0;
        @(negedge clk);
        nr_wr_en = 1'b0;
        check("R4", int'(nr_state), 0);

        // R3 SETUP clear beats a same-edge write of 1
        nr_wr_en = 1'b1; nr_wr_data = 1'b1;
        @(negedge clk);
        check("R4", int'(nr_state), 1);
        tok_valid = 1'b1; tok_kind = 3'd0; tok_ep = 4'd3;
        @(negedge clk);
        nr_wr_en = 1'b0; tok_valid = 1'b0;
        check("R3", int'(nr_state), 0);
        check("R2", int'(resp_code), 1);
        @(negedge clk);
        check("R1", int'(resp_valid), 0);
        check("R1", int'(resp_code), 0);

        // sweep
        for (int kind = 0; kind < 8; kind++) begin
            for (int ep = 0; ep < N_EP; ep++) begin
                for (int rdy = 0; rdy < 2; rdy++) begin
                    for (int stl = 0; stl < 2; stl++) begin
                        for (int g = 0; g < 2; g++) begin
                            for (int nr = 0; nr < 2; nr++) begin
                                for (int lpm = 0; lpm < 4; lpm++) begin
                                    nr_wr_en = 1'b1; nr_wr_data = nr[0];
                                    @(negedge clk);
                                    nr_wr_en = 1'b0;
                                    tok_valid = 1'b1;
                                    tok_kind = kind[2:0];
                                    tok_ep = ep[EP_W-1:0];
                                    ep_ready = rdy[0] ? N_EP'(1) << ep : ~(N_EP'(1) << ep);
                                    ep_stall = stl[0] ? N_EP'(1) << ep : ~(N_EP'(1) << ep);
                                    gnak_en = g[0];
                                    lpm_sel = lpm[1:0];
                                    @(negedge clk);
                                    tok_valid = 1'b0;
                                    check("R1", int'(resp_valid), 1);
                                    check(req_of(kind, ep, stl, g, nr), int'(resp_code),
                                          expect_code(kind, ep, rdy, stl, g, nr, lpm));
                                    check(kind == 0 ? "R3" : "R4", int'(nr_state),
                                          kind == 0 ? 0 : nr);
                                    @(negedge clk);
                                    check("R1", int'(resp_code), 0);
                                end
                            end
                        end
                    end
                end
            end
        end

        done = 1'b1;
        finish_run();
    end

endmodule